// File: doc/BRIEF.md
# Cyclic Passing-Window Phase Selector

This block chooses a sampling phase for a receive delay line after a sweep over all tap phases. The caller provides a mask in which bit n is set when phase n gave a clean read. The selector groups the passing phases into runs of consecutive indices and treats the top phase and phase 0 as neighbours. It then reports the phase that lies three quarters of the way into the longest run. Producing the mask is up to the caller.

A one-cycle start strobe captures the mask. The selector then walks the phases one per clock. When the walk ends it pulses a valid flag for one cycle, together with the chosen phase and an error flag. Both values stay on the outputs until the next accepted start. The sweep is sized by the parameter `NPH`, which defaults to 16 phases.

Top module: `phase_window_select`

## Requirements
- R1: An all-zero mask gives `err_o` = 1 and `phase_o` = 0 at the valid pulse. Any mask with at least one set bit gives `err_o` = 0.
- R2: Passing phases with consecutive ascending indices form one run. A clear bit between two set bits splits them into separate runs.
- R3: Suppose bit 0 and bit NPH-1 are both set and the mask is not all ones. The run that starts at phase 0 is then joined onto the end of the run that contains phase NPH-1. The merged run starts at that run's first phase and continues upward, wrapping to 0.
- R4: The run with the largest length is chosen. When lengths tie, the run that ends at the lower phase index wins. A merged run counts at the position of its upper part.
- R5: Let L be the length of the chosen run. The offset is floor(3L/4), reduced by one when it is non-zero. The output phase is (first phase of the run + offset) mod NPH. An all-ones mask is a single run of length NPH, which gives phase 11 at NPH = 16.
- R6: A start sampled at clock edge 0 makes `valid_o` high after edge NPH, for exactly one cycle. `phase_o` and `err_o` then hold until the next result.
- R7: While a selection is in progress, a start strobe and any change on the mask input have no effect on that result.
- R8: If a merged run would reach a length of NPH or more, the result is an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Captures the mask and begins a selection when idle |
| pass_mask_i | input | NPH | Bit n set means phase n passed |
| phase_o | output | $clog2(NPH) | Selected sampling phase |
| valid_o | output | 1 | One-cycle pulse when a result is presented |
| err_o | output | 1 | Set with the result when no usable phase exists |

## Verification
A wrong run length, start phase or merge decision inside the walk never shows until the valid pulse, exactly NPH cycles after start. At that point it appears as a phase off by one or more taps, or as a spurious error. A broken sequencer shows up sooner, as a valid pulse at the wrong cycle or lasting more than one cycle, or as outputs that drift while idle. The sweep therefore compares every result against an arithmetic model over several thousand distinct masks. It also pins the pulse timing and the hold behaviour with directed cases.

// File: rtl/phsel_pkg.sv
// Package: shared types for the phase window selector.
// Assumes: nothing beyond IEEE 1800-2017.
package phsel_pkg;
    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_BUSY = 1'b1
    } walk_state_e;
endpackage

// File: rtl/phsel_scan.sv
// Module: phsel_scan
// Walks the captured pass mask one phase per clock. It tracks the current
// run and the best run seen so far. When bit 0 and the top bit are both set
// (and the mask is not all ones), the run starting at 0 is held aside and
// added to the length of the run that ends at the top phase.
// Assumes: start_i is honoured only while idle; NPH >= 2.
module phsel_scan
    import phsel_pkg::*;
#(
    parameter int NPH = 16,
    parameter int PW  = $clog2(NPH),
    parameter int LW  = PW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [NPH-1:0] mask_i,
    output logic           fin_o,
    output logic [PW-1:0]  best_start_o,
    output logic [LW-1:0]  best_len_o,
    output logic           merge_err_o
);
    localparam logic [PW-1:0] LAST_IDX = PW'(NPH - 1);

    walk_state_e    st;
    logic [PW-1:0]  idx;
    logic [NPH-1:0] mask_q;
    logic           wrap_q;
    logic [LW-1:0]  cur_len, first_len, best_len;
    logic [PW-1:0]  cur_start, best_start;
    logic           merr;

    logic           bit_now, nxt_bit, last, run_end, zero_run, tail_run, take;
    logic [LW-1:0]  len_now, cand_len, nb_len;
    logic [PW-1:0]  start_now, nb_start;
    logic           nb_merr;

    // Evaluate the phase under the cursor and fold a finished run into the best.
    always_comb begin
        last      = (idx == LAST_IDX);
        bit_now   = mask_q[idx];
        nxt_bit   = last ? 1'b0 : mask_q[idx + 1'b1];
        len_now   = cur_len + 1'b1;
        start_now = (cur_len == '0) ? idx : cur_start;
        run_end   = bit_now & ~nxt_bit;
        zero_run  = wrap_q & (start_now == '0);
        tail_run  = wrap_q & last;
        cand_len  = tail_run ? (len_now + first_len) : len_now;
        take      = run_end & ~zero_run & (cand_len > best_len);
        nb_len    = take ? cand_len : best_len;
        nb_start  = take ? start_now : best_start;
        nb_merr   = merr | (run_end & tail_run & (cand_len >= LW'(NPH)));
    end

    assign fin_o        = (st == WALK_BUSY) & last;
    assign best_start_o = nb_start;
    assign best_len_o   = nb_len;
    assign merge_err_o  = nb_merr;

    // Sequencer: capture on start, then advance one phase per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= WALK_IDLE;
            idx        <= '0;
            mask_q     <= '0;
            wrap_q     <= 1'b0;
            cur_len    <= '0;
            cur_start  <= '0;
            first_len  <= '0;
            best_len   <= '0;
            best_start <= '0;
            merr       <= 1'b0;
        end else if (st == WALK_IDLE) begin
            if (start_i) begin
                st         <= WALK_BUSY;
                idx        <= '0;
                mask_q     <= mask_i;
                wrap_q     <= mask_i[0] & mask_i[NPH-1] & ~(&mask_i);
                cur_len    <= '0;
                cur_start  <= '0;
                first_len  <= '0;
                best_len   <= '0;
                best_start <= '0;
                merr       <= 1'b0;
            end
        end else begin
            cur_len    <= (bit_now & nxt_bit) ? len_now : '0;
            cur_start  <= start_now;
            best_len   <= nb_len;
            best_start <= nb_start;
            merr       <= nb_merr;
            if (run_end & zero_run) first_len <= len_now;
            idx <= idx + 1'b1;
            if (last) st <= WALK_IDLE;
        end
    end

    // R2: a run in progress can never be longer than the phases walked so far.
    p_run_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WALK_BUSY) |-> (cur_len <= LW'(idx)));
    // R3: on a wrapping mask the zero-based run is recorded before the top phase.
    p_first_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WALK_BUSY && wrap_q && idx == LAST_IDX) |-> (first_len != '0));
    // R5: the best recorded length never exceeds the phase count.
    p_best_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        best_len <= LW'(NPH));
endmodule

// File: rtl/phsel_pick.sv
// Module: phsel_pick
// Combinational: turns a run (first phase, length) into the phase at
// offset floor(3L/4), less one when non-zero, wrapped modulo NPH.
// Assumes: len_i <= 2*NPH.
module phsel_pick #(
    parameter int NPH = 16,
    parameter int PW  = $clog2(NPH),
    parameter int LW  = PW + 2
) (
    input  logic [PW-1:0] start_i,
    input  logic [LW-1:0] len_i,
    output logic [PW-1:0] phase_o
);
    localparam int XW = LW + 2;

    logic [XW-1:0] triple, pos, sum;

    // Offset arithmetic and modulo wrap.
    always_comb begin
        triple = (XW'(len_i) << 1) + XW'(len_i);
        pos    = triple >> 2;
        if (pos != '0) pos = pos - 1'b1;
        sum = XW'(start_i) + pos;
        if (sum >= XW'(NPH)) sum = sum - XW'(NPH);
        phase_o = sum[PW-1:0];
    end
endmodule

// File: rtl/phase_window_select.sv
// Module: phase_window_select (top)
// Accepts a pass mask on start, walks it over NPH cycles, and presents the
// chosen phase with a one-cycle valid pulse. Phase and error hold until the
// next result.
// Assumes: synchronous active-low reset; the caller waits for valid.
module phase_window_select #(
    parameter int NPH = 16,
    parameter int PW  = $clog2(NPH),
    parameter int LW  = PW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [NPH-1:0] pass_mask_i,
    output logic [PW-1:0]  phase_o,
    output logic           valid_o,
    output logic           err_o
);
    logic          fin;
    logic [PW-1:0] best_start, pick_phase;
    logic [LW-1:0] best_len;
    logic          merge_err, no_phase;

    phsel_scan #(.NPH(NPH), .PW(PW), .LW(LW)) u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mask_i       (pass_mask_i),
        .fin_o        (fin),
        .best_start_o (best_start),
        .best_len_o   (best_len),
        .merge_err_o  (merge_err)
    );

    phsel_pick #(.NPH(NPH), .PW(PW), .LW(LW)) u_pick (
        .start_i (best_start),
        .len_i   (best_len),
        .phase_o (pick_phase)
    );

    assign no_phase = (best_len == '0) | merge_err;

    // Result register: load on the final walk step, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= fin;
            if (fin) begin
                err_o   <= no_phase;
                phase_o <= no_phase ? '0 : pick_phase;
            end
        end
    end

    // R6: valid lasts one cycle.
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R6: outputs hold when no walk finishes.
    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> ($stable(phase_o) && $stable(err_o)));
    // R1: an error result carries phase 0.
    p_err_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && err_o) |-> (phase_o == '0));
endmodule

// File: tb/phase_window_select_bench.sv
module phase_window_select_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] mask = '0;
    logic [3:0]  phase;
    logic        valid, err;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    phase_window_select u_phase_window_select (
        .clk(clk), .rst_n(rst_n), .start_i(start), .pass_mask_i(mask),
        .phase_o(phase), .valid_o(valid), .err_o(err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Arithmetic model: list runs, merge wrap, pick longest, offset 3/4.
    function automatic void model(input logic [15:0] m, output int ph, output int er);
        int rs[16];
        int rl[16];
        int n = 0;
        int bi = 0;
        int bl = 0;
        int pos;
        for (int i = 0; i < 16; i++) begin
            if (m[i] && (i == 0 || !m[i-1])) begin
                rs[n] = i; rl[n] = 0; n++;
            end
            if (m[i]) rl[n-1]++;
        end
        ph = 0; er = 0;
        if (n == 0) begin er = 1; return; end
        if (n > 1 && rs[0] == 0 && rs[n-1] + rl[n-1] == 16) begin
            rl[n-1] += rl[0];
            rl[0] = 0;
            if (rl[n-1] >= 16) begin er = 1; return; end
        end
        for (int k = 0; k < n; k++)
            if (rl[k] > bl) begin bl = rl[k]; bi = k; end
        pos = (bl * 3) / 4;
        if (pos != 0) pos--;
        ph = (rs[bi] + pos) % 16;
    endfunction

    // One selection; full timing checks when tm is set.
    task automatic run(input logic [15:0] m, input string tag, input bit tm);
        int eph, eer;
        logic [3:0] held;
        model(m, eph, eer);
        @(negedge clk); mask = m; start = 1'b1;
        @(negedge clk); start = 1'b0; mask = ~m;
        repeat (15) @(negedge clk);
        if (tm) chk({tag, " R6 no early valid"}, valid, 0);
        @(negedge clk);
        chk({tag, " R6 valid"}, valid, 1);
        chk({tag, " phase"}, phase, eph);
        chk({tag, " R1 err"}, err, eer);
        held = phase;
        if (tm) begin
            @(negedge clk);
            chk({tag, " R6 pulse ends"}, valid, 0);
            repeat (3) @(negedge clk);
            chk({tag, " R6 phase held"}, phase, held);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int eph, eer;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset valid", valid, 0);
        chk("reset err", err, 0);
        chk("reset phase", phase, 0);

        run(16'h0000, "R1 empty", 1'b1);
        run(16'h00F0, "R2 single run", 1'b1);
        run(16'h0E70, "R2 gap split", 1'b0);
        run(16'h8003, "R3 wrap small", 1'b1);
        run(16'hE00F, "R3 wrap 7", 1'b0);
        run(16'h8001, "R3 wrap two", 1'b0);
        run(16'h0F0F, "R4 tie earliest", 1'b0);
        run(16'hC1E3, "R4 tie vs merged", 1'b0);
        run(16'hFFFF, "R5 all ones", 1'b1);
        run(16'h0010, "R5 length one", 1'b0);
        run(16'h0C00, "R5 length two", 1'b0);
        run(16'h7FFF, "R8 longest no wrap", 1'b0);
        run(16'hFFFE, "R8 top run", 1'b0);

        // R7: second start and mask change mid-walk are ignored.
        model(16'h3C00, eph, eer);
        @(negedge clk); mask = 16'h3C00; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        mask = 16'h0001; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        chk("R7 valid on time", valid, 1);
        chk("R7 busy start ignored", phase, eph);
        @(negedge clk);
        chk("R7 no second result", valid, 0);

        for (int k = 0; k < 6000; k++)
            run(16'((k * 40503) + 7), "R2 R3 R4 R5 sweep", 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule